// File: doc/BRIEF.md
# Two-Bit Branch History Table

This block keeps one two-bit saturating counter per table slot and uses it to guess the direction of conditional branches at fetch. A fetch PC goes in on the lookup side, and a taken or not-taken guess comes out in the same cycle with no register in the path. Once a branch has resolved, the pipeline sends its PC and its real direction to the update side. The selected counter then moves one step toward the outcome and holds at either end of its range. The slot is chosen from the low-order word-address bits of the PC. There are no tags, so PCs that share those bits share a counter.

A counter guesses not-taken only in its lowest state, 00. In each of the other three states it guesses taken. When the block leaves reset it steps through the table and writes 00 into one slot per clock. While that sweep runs the block makes no guess and drops any update it receives. The design expects a five-stage pipeline with no branch delay slot, where an update arrives a few cycles after the lookup of the same branch.

Top module: `bht_predictor`

## Requirements
- R1: Once reset is released, `pred_valid` stays low for exactly ENTRIES rising edges and is high from then on.
- R2: After the clear sweep, every slot holds 00, so every lookup returns not-taken until a taken update reaches that slot.
- R3: `pred_taken` is 1 when the selected counter is 01, 10 or 11, and 0 only when the counter is 00.
- R4: A taken update moves the counter up one state (00→01→10→11) and leaves it at 11 once it is there.
- R5: A not-taken update moves the counter down one state and leaves it at 00 once it is there.
- R6: The slot index is PC[IGNORE_LSB+IDX_W-1:IGNORE_LSB]. With the defaults this is PC[12:2]. The two byte-offset bits and all bits above the index have no effect on which slot is chosen.
- R7: If a lookup and an update select the same slot in the same cycle, the lookup returns the value from before the update. The new value is visible from the next cycle.
- R8: While the sweep runs, `pred_taken` is 0 and `upd_en` has no effect on any slot.
- R9: Asserting reset during normal operation starts the sweep again and returns every trained slot to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; starts the clear sweep |
| lk_pc | input | PC_W | PC of the fetch being predicted |
| pred_valid | output | 1 | High when the clear sweep is finished and guesses are valid |
| pred_taken | output | 1 | Taken guess for `lk_pc`, produced in the same cycle |
| upd_en | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Real direction of the resolved branch |

## Verification
The bench runs a 16-slot table. It first reads every slot directly after the sweep, with garbage in the offset bits, to confirm the clean start. It then drives one slot through runs of taken and not-taken updates longer than the counter range. The prediction flips only at the 00 boundary, which shows both saturation points and the three-versus-one split of the states. Separate phases check the following:
- Aliasing PCs, which show that only the index bits matter.
- Lookups that name the same slot as an update in the same cycle, which show the read-before-write order.
- A long pseudo-random mix of lookups and updates, checked against a counter model kept in the bench.
- A mid-run reset with updates driven during the sweep, which shows that trained slots are cleared and that those updates are lost.

// File: rtl/bht_pkg.sv
// Shared types and helpers for the two-bit branch history table.
package bht_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_FLOOR = 2'b00;
    localparam ctr_t CTR_CEIL  = 2'b11;

    // A counter guesses taken in every state except the floor.
    function automatic logic ctr_says_taken(input ctr_t c);
        return c != CTR_FLOOR;
    endfunction

endpackage

// File: rtl/bht_sweep.sv
// Clear sequencer. After reset it walks an index across every table slot,
// one slot per clock, and holds `clearing` high until the last slot is done.
// Assumes ENTRIES is a power of two.
module bht_sweep #(
    parameter int ENTRIES = 2048,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             clearing,
    output logic [IDX_W-1:0] clr_idx
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    // Step the sweep index while clearing; stop after the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clearing <= 1'b1;
            clr_idx  <= '0;
        end else if (clearing) begin
            if (clr_idx == LAST_IDX) begin
                clearing <= 1'b0;
                clr_idx  <= '0;
            end else begin
                clr_idx <= clr_idx + 1'b1;
            end
        end
    end

    AST_SWEEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (clearing && clr_idx != LAST_IDX) |=> (clearing && clr_idx == $past(clr_idx) + 1'b1)); // R1
    AST_SWEEP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (clearing && clr_idx == LAST_IDX) |=> !clearing); // R1
    AST_SWEEP_STAYS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !clearing |=> !clearing); // R1
    AST_RESET_RESTARTS: assert property (@(posedge clk)
        !rst_n |=> (clearing && clr_idx == '0)); // R9

endmodule

// File: rtl/bht_ctr_next.sv
// Saturating next-state function for one two-bit counter. A taken outcome
// moves the counter up one step and a not-taken outcome moves it down one
// step. Neither direction wraps. Purely combinational.
module bht_ctr_next
    import bht_pkg::*;
(
    input  ctr_t cur,
    input  logic taken,
    output ctr_t nxt
);

    // Move one step toward the outcome, holding at either end.
    always_comb begin
        if (taken) begin
            nxt = (cur == CTR_CEIL) ? CTR_CEIL : ctr_t'(cur + 2'd1);
        end else begin
            nxt = (cur == CTR_FLOOR) ? CTR_FLOOR : ctr_t'(cur - 2'd1);
        end
    end

endmodule

// File: rtl/bht_store.sv
// Counter storage. One write port and two asynchronous read ports: one read
// port serves the lookup and the other serves the update's read-modify-write.
// Reads return the contents from before any write in the same cycle.
module bht_store
    import bht_pkg::*;
#(
    parameter int ENTRIES = 2048,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_a_idx,
    output ctr_t             rd_a_val,
    input  logic [IDX_W-1:0] rd_b_idx,
    output ctr_t             rd_b_val,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  ctr_t             wr_val
);

    ctr_t mem [ENTRIES];

    // Write the selected slot; contents are initialised by the clear sweep.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_val;
        end
    end

    // Return the current contents on both read ports.
    always_comb begin
        rd_a_val = mem[rd_a_idx];
        rd_b_val = mem[rd_b_idx];
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem[$past(wr_idx)] == $past(wr_val))); // R2

endmodule

// File: rtl/bht_predictor.sv
// Direct-mapped two-bit branch history table. The lookup gives a
// combinational taken guess for a fetch PC. The update applies a resolved
// outcome to the slot selected by the branch PC. After reset the table is
// cleared by a sweep, and during the sweep there are no guesses and updates
// are dropped.
// Assumes ENTRIES is a power of two and that IGNORE_LSB+IDX_W <= PC_W.
module bht_predictor
    import bht_pkg::*;
#(
    parameter int ENTRIES    = 2048,
    parameter int PC_W       = 32,
    parameter int IGNORE_LSB = 2,
    localparam int IDX_W     = $clog2(ENTRIES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            pred_valid,
    output logic            pred_taken,
    input  logic            upd_en,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken
);

    logic             clearing;
    logic [IDX_W-1:0] clr_idx;
    logic [IDX_W-1:0] lk_idx;
    logic [IDX_W-1:0] upd_idx;
    ctr_t             lk_val;
    ctr_t             upd_cur;
    ctr_t             upd_nxt;
    logic             upd_fire;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    ctr_t             wr_val;
    logic             lint_unused;

    // Select the slot from the word-address bits of each PC.
    always_comb begin
        lk_idx  = lk_pc[IGNORE_LSB +: IDX_W];
        upd_idx = upd_pc[IGNORE_LSB +: IDX_W];
    end

    assign lint_unused = ^{lk_pc, upd_pc};

    bht_sweep #(.ENTRIES(ENTRIES)) u_sweep (
        .clk      (clk),
        .rst_n    (rst_n),
        .clearing (clearing),
        .clr_idx  (clr_idx)
    );

    bht_ctr_next u_next (
        .cur   (upd_cur),
        .taken (upd_taken),
        .nxt   (upd_nxt)
    );

    // Pick the write source: the clear sweep has priority over updates.
    always_comb begin
        upd_fire = upd_en && !clearing;
        wr_en    = clearing || upd_fire;
        wr_idx   = clearing ? clr_idx : upd_idx;
        wr_val   = clearing ? CTR_FLOOR : upd_nxt;
    end

    bht_store #(.ENTRIES(ENTRIES)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_a_idx (lk_idx),
        .rd_a_val (lk_val),
        .rd_b_idx (upd_idx),
        .rd_b_val (upd_cur),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_val   (wr_val)
    );

    // Drive the guess only once the table is clean.
    always_comb begin
        pred_valid = !clearing;
        pred_taken = pred_valid && ctr_says_taken(lk_val);
    end

    AST_QUIET_WHILE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_valid |-> !pred_taken); // R8
    AST_CLEAR_WRITES_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (clearing && wr_en) |-> (wr_val == CTR_FLOOR && wr_idx == clr_idx)); // R8
    AST_TAKEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_fire && upd_taken && upd_cur != CTR_CEIL) |-> (upd_nxt == ctr_t'(upd_cur + 2'd1))); // R4
    AST_TAKEN_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_fire && upd_taken && upd_cur == CTR_CEIL) |-> (upd_nxt == CTR_CEIL)); // R4
    AST_NOT_TAKEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_fire && !upd_taken && upd_cur != CTR_FLOOR) |-> (upd_nxt == ctr_t'(upd_cur - 2'd1))); // R5
    AST_NOT_TAKEN_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_fire && !upd_taken && upd_cur == CTR_FLOOR) |-> (upd_nxt == CTR_FLOOR)); // R5

endmodule

// File: tb/tb_bht_predictor.sv
module tb_bht_predictor;

    localparam int ENTRIES = 16;
    localparam int PC_W    = 16;
    localparam int OFF     = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] lk_pc = '0;
    logic            pred_valid;
    logic            pred_taken;
    logic            upd_en = 1'b0;
    logic [PC_W-1:0] upd_pc = '0;
    logic            upd_taken = 1'b0;

    int checks = 0;
    int errors = 0;
    int mdl [ENTRIES];
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    bht_predictor #(.ENTRIES(ENTRIES), .PC_W(PC_W), .IGNORE_LSB(OFF)) dut (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .pred_valid(pred_valid),
        .pred_taken(pred_taken), .upd_en(upd_en), .upd_pc(upd_pc), .upd_taken(upd_taken)
    );

    function automatic int slot_of(input logic [PC_W-1:0] pc);
        return (int'(pc) / 4) % ENTRIES;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, check the guess, advance the model at the edge.
    task automatic step(input string req, input logic [PC_W-1:0] lpc, input logic en,
                        input logic [PC_W-1:0] upc, input logic tk);
        lk_pc = lpc; upd_en = en; upd_pc = upc; upd_taken = tk;
        #1;
        chk(req, int'(pred_taken), int'(mdl[slot_of(lpc)] != 0));
        @(posedge clk);
        if (en) begin
            if (tk) mdl[slot_of(upc)] = (mdl[slot_of(upc)] == 3) ? 3 : mdl[slot_of(upc)] + 1;
            else    mdl[slot_of(upc)] = (mdl[slot_of(upc)] == 0) ? 0 : mdl[slot_of(upc)] - 1;
        end
        @(negedge clk);
        upd_en = 1'b0;
    endtask

    // Reset, then count the sweep while trying to update slot 0 throughout.
    task automatic do_reset(input string req);
        int k = 0;
        @(negedge clk);
        rst_n = 1'b0; upd_en = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R8 quiet at release", int'(pred_taken), 0);
        while (k < 1000) begin
            upd_en = 1'b1; upd_pc = '0; upd_taken = 1'b1; lk_pc = '0;
            @(posedge clk);
            @(negedge clk);
            k++;
            if (pred_valid) break;
            chk("R8 no guess during sweep", int'(pred_taken), 0);
        end
        upd_en = 1'b0;
        chk(req, k, ENTRIES);
        for (int i = 0; i < ENTRIES; i++) mdl[i] = 0;
    endtask

    initial begin
        for (int i = 0; i < ENTRIES; i++) mdl[i] = 0;
        repeat (2) @(posedge clk);
        do_reset("R1 sweep length");

        // R8: slot 0 was hit by taken updates during the sweep and must still be clear.
        step("R8 updates during sweep dropped", 16'h0000, 1'b0, '0, 1'b0);

        // R2: every slot reads not-taken after the sweep, with junk in the offset bits.
        for (int i = 0; i < ENTRIES; i++)
            step("R2 clean slot", PC_W'(i * 4 + (i % 4)), 1'b0, '0, 1'b0);

        // R4/R3: climb slot 3 past the top.
        for (int n = 0; n < 5; n++)
            step("R4 taken climb", 16'h000C, 1'b1, 16'h000C, 1'b1);
        // R5/R3: fall past the bottom; the guess flips only at 00.
        for (int n = 0; n < 5; n++)
            step("R5 not-taken fall", 16'h000C, 1'b1, 16'h000C, 1'b0);
        step("R3 floor guesses not-taken", 16'h000C, 1'b0, '0, 1'b0);
        step("R4 one taken from floor", 16'h000C, 1'b1, 16'h000C, 1'b1);
        step("R3 state 01 guesses taken", 16'h000C, 1'b0, '0, 1'b0);

        // R6: update through aliases that differ in offset bits and upper bits.
        step("R6 alias update", 16'h0014, 1'b1, 16'h0017 | 16'(1 << (OFF + 4)), 1'b1);
        step("R6 alias visible", 16'h0014, 1'b1, 16'hF015, 1'b1);
        step("R6 other slot untouched", 16'h0018, 1'b0, '0, 1'b0);

        // R7: lookup and update on the same slot in the same cycle.
        step("R7 pre-update value", 16'h0020, 1'b1, 16'h0020, 1'b1);
        step("R7 new value next cycle", 16'h0020, 1'b1, 16'h0020, 1'b0);
        step("R7 back to floor", 16'h0020, 1'b0, '0, 1'b0);

        // R3: long pseudo-random mix against the model.
        for (int n = 0; n < 3000; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step("R3 random mix", PC_W'(lfsr[7:0] ^ lfsr[15:8]), lfsr[0] | lfsr[1],
                 PC_W'({lfsr[3:0], lfsr[15:12], lfsr[9:8]}), lfsr[5] | lfsr[6]);
        end

        // R9: train every slot to 11, reset mid-run, then all must read not-taken.
        for (int i = 0; i < ENTRIES; i++)
            for (int n = 0; n < 3; n++)
                step("R4 train", PC_W'(i * 4), 1'b1, PC_W'(i * 4), 1'b1);
        for (int i = 0; i < ENTRIES; i++)
            step("R3 trained", PC_W'(i * 4), 1'b0, '0, 1'b0);
        do_reset("R9 sweep length after mid-run reset");
        for (int i = 0; i < ENTRIES; i++)
            step("R9 cleared slot", PC_W'(i * 4), 1'b0, '0, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule